// File: doc/BRIEF.md
# Serial Bus Slave Acknowledge Arbiter

This block sits in the slave side of a multi-master serial bus receiver. For every frame addressed to the unit it decides, at the end of the control field, the message-length field and each data byte, whether the slave answers with ACK or NAK. The bit-level receiver upstream supplies each decoded field with its parity verdict and a timing-error flag. Buffer status comes from the data path. The arbiter itself holds the unit's lock state and the address of the master that owns the lock.

Each decision appears as a one-cycle `ack_valid` strobe with `ack_nak` (0 = ACK, 1 = NAK). An `abort` strobe ends the frame early. A `frame_done` strobe marks a frame that completed cleanly, and in that same cycle the lock state is updated. The sequencer has four phases: PH_IDLE, PH_CTRL, PH_LEN and PH_DATA. Its transitions are:
- start: any phase goes to PH_CTRL on `frame_start`.
- ctrl-accept: PH_CTRL to PH_LEN. ctrl-reject: PH_CTRL to PH_IDLE.
- len-accept: PH_LEN to PH_DATA. len-reject: PH_LEN to PH_IDLE.
- byte-last: PH_DATA to PH_IDLE when the frame completes.
- byte-retry: stay in PH_DATA after a rejected byte.
- byte-limit: PH_DATA to PH_IDLE when the transfer cap is reached.

Top module: `serial_ack_arbiter`

## Requirements
- R1: After reset no strobe is active, the phase is idle, `locked` is 0 and `lock_owner` is 0.
- R2: A `field_done` accepted in an active phase yields `ack_valid` for exactly the next cycle, with `ack_nak` 0 for ACK and 1 for NAK. A `field_done` in the idle phase, or in the same cycle as `frame_start`, gives no `ack_valid`.
- R3: A control field (low 4 bits of `field_value`) is NAKed and the frame aborted when its parity is bad or a timing error was flagged since the last acknowledge; a `timing_err` in the same cycle as `field_done` counts for that field only.
- R4: Control codes 1, 2, 8, 9, C and D are undefined and always NAKed.
- R5: A control code with bit 3 set (write) is NAKed when `rx_empty` is 0.
- R6: Read-data codes 3 and 7 are NAKed when `tx_empty` is 1.
- R7: While locked, a master other than `lock_owner` is NAKed for codes 3, 6, 7, A, B, E and F; codes 0, 4 and 5 stay allowed.
- R8: Lock-address reads (codes 4 and 5) are NAKed while unlocked.
- R9: The length field is NAKed and the frame aborted on bad parity or timing error; a length value of 0 stands for 2^8 = 256 bytes.
- R10: A data byte is NAKed on bad parity, on a timing error at any time since the previous acknowledge, or when `rx_full` is 1.
- R11: A NAKed data byte does not end the frame (the master repeats it); each data field counts toward a cap of MAX_XFER (32) transfers, and the field that reaches the cap without completing the frame carries `abort`.
- R12: When the ACKed byte count reaches the frame length, `frame_done` pulses together with that byte's ACK.
- R13: On `frame_done`, codes 3, A and B set `locked` and load `lock_owner` with the frame's master address; codes 7, E and F from the owner clear `locked`; nothing else changes the lock.
- R14: `frame_start` in any phase restarts the frame at the control field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | A new frame addressed to this unit begins |
| master_addr | input | ADDR_W | Address of the requesting master, sampled at `frame_start` |
| field_done | input | 1 | A field has just been received |
| field_value | input | FIELD_W | Decoded field contents |
| parity_ok | input | 1 | Parity of the field was correct |
| timing_err | input | 1 | Timing error from the bit-level receiver |
| rx_empty | input | 1 | Slave receive buffer is empty |
| rx_full | input | 1 | Slave receive buffer cannot take more data |
| tx_empty | input | 1 | Slave transmit buffer is empty |
| ack_valid | output | 1 | Acknowledge decision strobe |
| ack_nak | output | 1 | 0 = ACK, 1 = NAK, valid with `ack_valid` |
| abort | output | 1 | Frame terminated early |
| frame_done | output | 1 | Frame completed without termination |
| locked | output | 1 | Unit is locked |
| lock_owner | output | ADDR_W | Address of the locking master |

## Verification
Two functions can fall in the same cycle: the latching of a `timing_err` pulse and the acknowledge that consumes the latched flag. The bench raises `timing_err` together with a control `field_done` and expects a NAK for that field. It then restarts the frame and expects the next control field to be ACKed, which shows the flag was consumed rather than carried over. In a separate test a `timing_err` pulse between two data fields must taint the later byte. A second coincidence, the final data ACK landing with the lock update, is judged by sampling `frame_done`, `locked` and `lock_owner` in the same cycle.

// File: rtl/ack_arb_pkg.sv
package ack_arb_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CTRL,
        PH_LEN,
        PH_DATA
    } phase_t;

    function automatic logic code_defined(input logic [3:0] c);
        case (c)
            4'h1, 4'h2, 4'h8, 4'h9, 4'hC, 4'hD: return 1'b0;
            default:                            return 1'b1;
        endcase
    endfunction

    function automatic logic code_reads_data(input logic [3:0] c);
        return (c == 4'h3) || (c == 4'h7);
    endfunction

    function automatic logic code_guarded(input logic [3:0] c);
        case (c)
            4'h3, 4'h6, 4'h7, 4'hA, 4'hB, 4'hE, 4'hF: return 1'b1;
            default:                                  return 1'b0;
        endcase
    endfunction

    function automatic logic code_lock_addr(input logic [3:0] c);
        return (c == 4'h4) || (c == 4'h5);
    endfunction

    function automatic logic code_locks(input logic [3:0] c);
        return (c == 4'h3) || (c == 4'hA) || (c == 4'hB);
    endfunction

    function automatic logic code_unlocks(input logic [3:0] c);
        return (c == 4'h7) || (c == 4'hE) || (c == 4'hF);
    endfunction

endpackage

// File: rtl/ack_ctrl_judge.sv
module ack_ctrl_judge
    import ack_arb_pkg::*;
(
    input  logic [3:0] code,
    input  logic       parity_ok,
    input  logic       timing_hit,
    input  logic       rx_empty,
    input  logic       tx_empty,
    input  logic       locked,
    input  logic       owner_match,
    output logic       nak
);
    logic bad_link, bad_code, bad_buffer, bad_lock;

    always_comb begin
        bad_link   = !parity_ok || timing_hit;
        bad_code   = !code_defined(code);
        bad_buffer = (code[3] && !rx_empty) || (code_reads_data(code) && tx_empty);
        bad_lock   = (locked && !owner_match && code_guarded(code))
                   || (code_lock_addr(code) && !locked);
        nak        = bad_link || bad_code || bad_buffer || bad_lock;
    end
endmodule

// File: rtl/ack_lock_keeper.sv
module ack_lock_keeper
    import ack_arb_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [3:0]        code,
    input  logic [ADDR_W-1:0] master,
    output logic              locked,
    output logic [ADDR_W-1:0] owner
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            owner  <= '0;
        end else if (commit) begin
            if (code_locks(code)) begin
                locked <= 1'b1;
                owner  <= master;
            end else if (code_unlocks(code) && locked && (owner == master)) begin
                locked <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ack_xfer_tracker.sv
module ack_xfer_tracker #(
    parameter int LEN_W    = 8,
    parameter int MAX_XFER = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             step,
    input  logic             accepted,
    output logic             last_byte,
    output logic             at_limit
);
    localparam int REM_W = LEN_W + 1;
    localparam int CNT_W = $clog2(MAX_XFER + 1);
    localparam logic [CNT_W-1:0] CAP_LAST = CNT_W'(MAX_XFER - 1);

    logic [REM_W-1:0] remaining;
    logic [CNT_W-1:0] xfers;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
            xfers     <= '0;
        end else if (load) begin
            remaining <= (len == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, len};
            xfers     <= '0;
        end else if (step) begin
            xfers <= xfers + 1'b1;
            if (accepted) remaining <= remaining - 1'b1;
        end
    end

    assign last_byte = (remaining == REM_W'(1));
    assign at_limit  = (xfers == CAP_LAST);
endmodule

// File: rtl/serial_ack_arbiter.sv
module serial_ack_arbiter
    import ack_arb_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int FIELD_W  = 8,
    parameter int MAX_XFER = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic [ADDR_W-1:0]  master_addr,
    input  logic               field_done,
    input  logic [FIELD_W-1:0] field_value,
    input  logic               parity_ok,
    input  logic               timing_err,
    input  logic               rx_empty,
    input  logic               rx_full,
    input  logic               tx_empty,
    output logic               ack_valid,
    output logic               ack_nak,
    output logic               abort,
    output logic               frame_done,
    output logic               locked,
    output logic [ADDR_W-1:0]  lock_owner
);
    localparam int CODE_W = 4;

    phase_t              phase_q, phase_d;
    logic [ADDR_W-1:0]   master_q;
    logic [CODE_W-1:0]   code_q;
    logic                te_sticky;
    logic                te_now;
    logic                ctrl_nak;
    logic                last_byte, at_limit;
    logic                ack_d, nak_d, abort_d, done_d;
    logic                load_len, step_byte, commit;

    assign te_now = te_sticky || timing_err;

    ack_ctrl_judge u_judge (
        .code        (field_value[CODE_W-1:0]),
        .parity_ok   (parity_ok),
        .timing_hit  (te_now),
        .rx_empty    (rx_empty),
        .tx_empty    (tx_empty),
        .locked      (locked),
        .owner_match (lock_owner == master_q),
        .nak         (ctrl_nak)
    );

    ack_xfer_tracker #(.LEN_W(FIELD_W), .MAX_XFER(MAX_XFER)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_len),
        .len       (field_value),
        .step      (step_byte),
        .accepted  (!nak_d),
        .last_byte (last_byte),
        .at_limit  (at_limit)
    );

    ack_lock_keeper #(.ADDR_W(ADDR_W)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .code   (code_q),
        .master (master_q),
        .locked (locked),
        .owner  (lock_owner)
    );

    // Next phase and per-field decision
    always_comb begin
        phase_d   = phase_q;
        ack_d     = 1'b0;
        nak_d     = 1'b0;
        abort_d   = 1'b0;
        done_d    = 1'b0;
        load_len  = 1'b0;
        step_byte = 1'b0;
        commit    = 1'b0;
        if (frame_start) begin
            phase_d = PH_CTRL;
        end else if (field_done) begin
            unique case (phase_q)
                PH_IDLE: begin
                end
                PH_CTRL: begin
                    ack_d = 1'b1;
                    nak_d = ctrl_nak;
                    if (ctrl_nak) begin
                        abort_d = 1'b1;
                        phase_d = PH_IDLE;
                    end else begin
                        phase_d = PH_LEN;
                    end
                end
                PH_LEN: begin
                    ack_d = 1'b1;
                    nak_d = !parity_ok || te_now;
                    if (nak_d) begin
                        abort_d = 1'b1;
                        phase_d = PH_IDLE;
                    end else begin
                        load_len = 1'b1;
                        phase_d  = PH_DATA;
                    end
                end
                PH_DATA: begin
                    ack_d     = 1'b1;
                    step_byte = 1'b1;
                    nak_d     = !parity_ok || te_now || rx_full;
                    if (!nak_d && last_byte) begin
                        done_d  = 1'b1;
                        commit  = 1'b1;
                        phase_d = PH_IDLE;
                    end else if (at_limit) begin
                        abort_d = 1'b1;
                        phase_d = PH_IDLE;
                    end
                end
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    // State register and frame context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            master_q  <= '0;
            code_q    <= '0;
            te_sticky <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (frame_start) master_q <= master_addr;
            if (field_done && !frame_start && phase_q == PH_CTRL)
                code_q <= field_value[CODE_W-1:0];
            if (frame_start || ack_d) te_sticky <= 1'b0;
            else if (timing_err)      te_sticky <= 1'b1;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid  <= 1'b0;
            ack_nak    <= 1'b0;
            abort      <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            ack_valid  <= ack_d;
            ack_nak    <= nak_d;
            abort      <= abort_d;
            frame_done <= done_d;
        end
    end
endmodule

// File: rtl/ack_arb_checker.sv
module ack_arb_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              field_done,
    input logic              parity_ok,
    input logic              timing_err,
    input logic              ack_valid,
    input logic              ack_nak,
    input logic              abort,
    input logic              frame_done,
    input logic              locked,
    input logic [ADDR_W-1:0] lock_owner
);
    assert_ack_needs_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(field_done) |-> !ack_valid);

    assert_parity_nak_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !$past(parity_ok)) |-> ack_nak);

    assert_timing_nak_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && $past(timing_err)) |-> ack_nak);

    assert_abort_on_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (ack_valid && !frame_done));

    assert_done_is_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (ack_valid && !ack_nak));

    assert_lock_only_on_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |-> ($stable(locked) && $stable(lock_owner)));
endmodule

bind serial_ack_arbiter ack_arb_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .field_done (field_done),
    .parity_ok  (parity_ok),
    .timing_err (timing_err),
    .ack_valid  (ack_valid),
    .ack_nak    (ack_nak),
    .abort      (abort),
    .frame_done (frame_done),
    .locked     (locked),
    .lock_owner (lock_owner)
);

// File: tb/tb_serial_ack_arbiter.sv
module tb_serial_ack_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;
    localparam int MAXX = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic [ADDR_W-1:0] master_addr = '0;
    logic field_done = 1'b0;
    logic [7:0] field_value = '0;
    logic parity_ok = 1'b1;
    logic timing_err = 1'b0;
    logic rx_empty = 1'b1;
    logic rx_full = 1'b0;
    logic tx_empty = 1'b0;
    logic ack_valid, ack_nak, abort, frame_done, locked;
    logic [ADDR_W-1:0] lock_owner;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic s_v, s_n, s_a, s_d;

    serial_ack_arbiter dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start(input logic [ADDR_W-1:0] a);
        frame_start = 1'b1; master_addr = a;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic field(input logic [7:0] v, input logic par, input logic te);
        field_done = 1'b1; field_value = v; parity_ok = par; timing_err = te;
        @(negedge clk);
        s_v = ack_valid; s_n = ack_nak; s_a = abort; s_d = frame_done;
        field_done = 1'b0; parity_ok = 1'b1; timing_err = 1'b0;
    endtask

    task automatic ctrl_expect(input logic [ADDR_W-1:0] a, input logic [3:0] c,
                               input logic nak, input string req);
        start(a);
        field({4'h0, c}, 1'b1, 1'b0);
        chk({req, " ack_valid"}, s_v, 1);
        chk({req, " ack_nak"}, s_n, nak);
        chk({req, " abort"}, s_a, nak);
    endtask

    task automatic t_reset();
        chk("R1 ack_valid", ack_valid, 0);
        chk("R1 abort", abort, 0);
        chk("R1 frame_done", frame_done, 0);
        chk("R1 locked", locked, 0);
        chk("R1 owner", lock_owner, 0);
    endtask

    task automatic t_idle_ignored();
        field(8'h00, 1'b1, 1'b0);
        chk("R2 idle field no ack", s_v, 0);
        frame_start = 1'b1; master_addr = 12'h010;
        field(8'h00, 1'b1, 1'b0);
        frame_start = 1'b0;
        chk("R2 field with start no ack", s_v, 0);
    endtask

    task automatic t_control_rules();
        logic [3:0] undef [6] = '{4'h1, 4'h2, 4'h8, 4'h9, 4'hC, 4'hD};
        foreach (undef[i]) ctrl_expect(12'h010, undef[i], 1'b1, "R4 undefined");
        start(12'h010); field(8'h06, 1'b0, 1'b0);
        chk("R3 ctrl parity nak", s_n, 1); chk("R3 ctrl parity abort", s_a, 1);
        rx_empty = 1'b0;
        ctrl_expect(12'h010, 4'hE, 1'b1, "R5 write rx busy");
        rx_empty = 1'b1;
        ctrl_expect(12'h010, 4'hE, 1'b0, "R5 write rx empty");
        tx_empty = 1'b1;
        ctrl_expect(12'h010, 4'h3, 1'b1, "R6 read tx empty");
        ctrl_expect(12'h010, 4'h6, 1'b0, "R6 status with tx empty");
        tx_empty = 1'b0;
        ctrl_expect(12'h010, 4'h7, 1'b0, "R6 read tx ready");
        ctrl_expect(12'h010, 4'h4, 1'b1, "R8 lock addr unlocked");
        ctrl_expect(12'h010, 4'h5, 1'b1, "R8 lock addr hi unlocked");
    endtask

    task automatic t_timing_coincident();
        start(12'h010); field(8'h06, 1'b1, 1'b1);
        chk("R3 timing with field nak", s_n, 1);
        ctrl_expect(12'h010, 4'h6, 1'b0, "R3 timing flag consumed");
    endtask

    task automatic t_lock_frame();
        start(12'h123);
        field(8'h0B, 1'b1, 1'b0); chk("R12 ctrl ack", s_n, 0);
        field(8'h02, 1'b1, 1'b0); chk("R12 len ack", s_n, 0);
        field(8'h55, 1'b1, 1'b0); chk("R12 first byte not done", s_d, 0);
        chk("R13 not locked yet", locked, 0);
        field(8'hAA, 1'b1, 1'b0);
        chk("R12 last byte done", s_d, 1); chk("R12 last byte ack", s_n, 0);
        chk("R13 locked", locked, 1); chk("R13 owner", lock_owner, 12'h123);
    endtask

    task automatic t_foreign_master();
        ctrl_expect(12'h055, 4'hF, 1'b1, "R7 foreign write");
        ctrl_expect(12'h055, 4'h6, 1'b1, "R7 foreign status6");
        ctrl_expect(12'h055, 4'h0, 1'b0, "R7 foreign status0");
        ctrl_expect(12'h055, 4'h4, 1'b0, "R7 foreign lock addr");
        ctrl_expect(12'h123, 4'hA, 1'b0, "R7 owner lock cmd");
    endtask

    task automatic t_len_errors();
        start(12'h123); field(8'h06, 1'b1, 1'b0);
        field(8'h04, 1'b0, 1'b0);
        chk("R9 len parity nak", s_n, 1); chk("R9 len parity abort", s_a, 1);
        start(12'h123); field(8'h06, 1'b1, 1'b0);
        field(8'h04, 1'b1, 1'b1);
        chk("R9 len timing nak", s_n, 1);
    endtask

    task automatic t_data_retry_unlock();
        start(12'h123);
        field(8'h0F, 1'b1, 1'b0);
        field(8'h01, 1'b1, 1'b0);
        rx_full = 1'b1;
        field(8'h11, 1'b1, 1'b0);
        rx_full = 1'b0;
        chk("R10 rx full nak", s_n, 1); chk("R11 retry no abort", s_a, 0);
        field(8'h11, 1'b0, 1'b0);
        chk("R10 data parity nak", s_n, 1);
        timing_err = 1'b1; @(negedge clk); timing_err = 1'b0;
        @(negedge clk);
        field(8'h11, 1'b1, 1'b0);
        chk("R10 sticky timing nak", s_n, 1); chk("R11 still no abort", s_a, 0);
        field(8'h11, 1'b1, 1'b0);
        chk("R10 clean byte ack", s_n, 0); chk("R12 done after retry", s_d, 1);
        chk("R13 owner unlock", locked, 0);
    endtask

    task automatic t_limit_naks();
        start(12'h200); field(8'h06, 1'b1, 1'b0); field(8'h01, 1'b1, 1'b0);
        rx_full = 1'b1;
        for (int i = 1; i < MAXX; i++) begin
            field(8'h00, 1'b1, 1'b0);
            if (s_a) chk("R11 early abort", i, MAXX);
        end
        field(8'h00, 1'b1, 1'b0);
        rx_full = 1'b0;
        chk("R11 cap abort", s_a, 1); chk("R11 cap nak", s_n, 1);
    endtask

    task automatic t_len_zero();
        start(12'h200); field(8'h00, 1'b1, 1'b0); field(8'h00, 1'b1, 1'b0);
        chk("R9 zero len ack", s_n, 0);
        for (int i = 1; i < MAXX; i++) begin
            field(8'h00, 1'b1, 1'b0);
            if (s_d || s_a) chk("R9 zero len ended early", i, MAXX);
        end
        field(8'h00, 1'b1, 1'b0);
        chk("R11 cap abort on ack", s_a, 1); chk("R9 no done at cap", s_d, 0);
    endtask

    task automatic t_restart();
        start(12'h010); field(8'h06, 1'b1, 1'b0);
        start(12'h010); field(8'h01, 1'b1, 1'b0);
        chk("R14 restart treats as control", s_n, 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_ignored();
        t_control_rules();
        t_timing_coincident();
        t_lock_frame();
        t_foreign_master();
        t_len_errors();
        t_data_retry_unlock();
        t_limit_naks();
        t_len_zero();
        t_restart();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end
endmodule